// File: doc/BRIEF.md
# Release-Reporting Key Debouncer

This block cleans up a bank of active-low push switches, eight by default. It does not filter each contact on its own. Instead it uses a blackout window. Each time the sampled pattern moves away from the pattern it has on record, the block starts a timer. Until that timer expires, every strobe is ignored. The raw lines first pass through a synchronizer chain, and they are looked at only on cycles where the sample strobe is high.

Presses are never reported when they happen. A new non-idle pattern is only recorded. When the switches return to all ones (nothing pressed), the block emits the recorded pattern for exactly one cycle, with a valid pulse beside it. It then forgets the pattern.

The output is a plain valid pulse with no ready. A consumer that is not listening in that cycle loses the report, and the block never stalls. The blackout length is derived from the clock frequency and a duration in microseconds. The default is 10 ms.

Top module: `key_release_debouncer`

## Requirements
- R1: After reset, `key_code` is all ones, `key_valid` is 0, and the recorded pattern is all ones (idle).
- R2: In every cycle without a report, `key_code` is all ones.
- R3: A cycle with `smp_en` low makes no decision: no report and no change to the recorded pattern, whatever `raw_keys` does.
- R4: When a strobe sees a synchronized pattern that is not all ones and differs from the record, the pattern is recorded, the blackout starts, and nothing is reported.
- R5: When a strobe sees all ones while the record is not all ones, `key_valid` pulses high for exactly one cycle with `key_code` equal to the record. The record then returns to all ones, and further strobes on an idle bank report nothing.
- R6: A strobe that sees the same pattern as the record produces no report and starts no blackout.
- R7: A decision that records or reports holds off all later decisions for BLACKOUT_US·CLK_HZ/10^6 clock cycles. A switch change made and undone inside that window leaves no trace. From a drive of a new pattern with the strobe held high, the record happens at the third rising edge, and a release driven at once is reported at edge N+4 (N = blackout cycles).
- R8: `raw_keys` reaches the comparison only through a two-stage synchronizer. A strobe at the first or second rising edge after a raw change still sees the old value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raw_keys | input | KEY_W | Raw switch lines, low = pressed |
| smp_en | input | 1 | Sample strobe; decisions are made only when high |
| key_code | output | KEY_W | Reported pattern, all ones when idle |
| key_valid | output | 1 | One-cycle pulse marking a report |

## Verification
The bench targets cases where a plausible design goes wrong:

- A switch bounce inside the blackout that settles back: a design that watches the inputs during the blackout would record the bounce pattern and report the wrong code.
- A direct move from one pressed pattern to another: a design that keeps the first code would report stale data.
- A held key under repeated strobes: a design that reports on equality would emit duplicates.
- Exact timing: the cycle of the release report pins down the blackout length and the synchronizer depth. A strobe that lasts only the first two edges after a press must not record it, which exposes a missing synchronizer stage.
- Strobe gating and the idle state after a report: these catch designs that decide on every clock or report twice.

// File: rtl/kd_pkg.sv
package kd_pkg;
  // Outcome of one strobe evaluation.
  typedef enum logic [1:0] {
    KD_SKIP   = 2'd0,  // no strobe or blackout active
    KD_SAME   = 2'd1,  // pattern equals the record
    KD_RECORD = 2'd2,  // new pressed pattern, keep it
    KD_REPORT = 2'd3   // release seen, emit the record
  } kd_dec_e;

  function automatic int unsigned kd_cycles(input int unsigned clk_hz,
                                            input int unsigned dur_us);
    int unsigned c;
    c = (clk_hz / 1_000_000) * dur_us;
    if (c == 0) c = 1;
    return c;
  endfunction
endpackage

// File: rtl/kd_sync.sv
module kd_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_in,
  output logic [W-1:0] d_out
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[0] <= '1;
        else        stage_q[0] <= d_in;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '1;
        else        stage_q[s] <= stage_q[s-1];
      end
    end
  end

  assign d_out = stage_q[STAGES-1];
endmodule

// File: rtl/kd_blackout.sv
module kd_blackout #(
  parameter int unsigned CYC = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(CYC + 1);
  localparam logic [CW-1:0] LOAD = CW'(CYC);

  logic [CW-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          remain_q <= '0;
    else if (start)      remain_q <= LOAD;
    else if (remain_q != '0) remain_q <= remain_q - 1'b1;
  end

  assign busy = (remain_q != '0);
endmodule

// File: rtl/kd_tracker.sv
module kd_tracker
  import kd_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         smp_en,
  input  logic         busy,
  input  logic [W-1:0] pat,
  output logic         start,
  output logic [W-1:0] held,
  output logic [W-1:0] code,
  output logic         valid
);
  localparam logic [W-1:0] IDLE = '1;

  kd_dec_e dec;

  always_comb begin
    if (!smp_en || busy)  dec = KD_SKIP;
    else if (pat == held) dec = KD_SAME;
    else if (pat == IDLE) dec = KD_REPORT;
    else                  dec = KD_RECORD;
  end

  assign start = (dec == KD_RECORD) || (dec == KD_REPORT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      held  <= IDLE;
      code  <= IDLE;
      valid <= 1'b0;
    end else begin
      code  <= (dec == KD_REPORT) ? held : IDLE;
      valid <= (dec == KD_REPORT);
      case (dec)
        KD_RECORD: held <= pat;
        KD_REPORT: held <= IDLE;
        default:   held <= held;
      endcase
    end
  end
endmodule

// File: rtl/key_release_debouncer.sv
module key_release_debouncer #(
  parameter int          KEY_W       = 8,
  parameter int unsigned CLK_HZ      = 100_000_000,
  parameter int unsigned BLACKOUT_US = 10_000,
  parameter int          SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [KEY_W-1:0] raw_keys,
  input  logic             smp_en,
  output logic [KEY_W-1:0] key_code,
  output logic             key_valid
);
  localparam int unsigned BLK_CYC = kd_pkg::kd_cycles(CLK_HZ, BLACKOUT_US);

  logic [KEY_W-1:0] synced;
  logic [KEY_W-1:0] held_pat;
  logic             blk_start;
  logic             blk_busy;

  kd_sync #(.W(KEY_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d_in  (raw_keys),
    .d_out (synced)
  );

  kd_blackout #(.CYC(BLK_CYC)) u_blk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (blk_start),
    .busy  (blk_busy)
  );

  kd_tracker #(.W(KEY_W)) u_trk (
    .clk    (clk),
    .rst_n  (rst_n),
    .smp_en (smp_en),
    .busy   (blk_busy),
    .pat    (synced),
    .start  (blk_start),
    .held   (held_pat),
    .code   (key_code),
    .valid  (key_valid)
  );
endmodule

// File: rtl/kd_checker.sv
module kd_checker #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic         smp_en,
  input logic         key_valid,
  input logic [W-1:0] key_code,
  input logic         busy,
  input logic [W-1:0] stored
);
  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    !key_valid |-> key_code == '1); // R2

  AST_STROBE_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> (!key_valid && $stable(stored))); // R3

  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |=> !key_valid); // R5

  AST_REPORT_NOT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> key_code != '1); // R5

  AST_REPORT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> stored == '1); // R5

  AST_REPORT_ARMS_BLACKOUT: assert property (@(posedge clk) disable iff (!rst_n)
    key_valid |-> busy); // R7

  AST_BLACKOUT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!key_valid && $stable(stored))); // R7
endmodule

bind key_release_debouncer kd_checker #(.W(KEY_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .smp_en    (smp_en),
  .key_valid (key_valid),
  .key_code  (key_code),
  .busy      (blk_busy),
  .stored    (held_pat)
);

// File: tb/key_release_debouncer_test.sv
module key_release_debouncer_test;
  localparam int N      = 20;  // blackout cycles: 1 MHz scale * 20 us
  localparam int SETTLE = N + 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] raw_keys = 8'hFF;
  logic       smp_en = 1'b0;
  logic [7:0] key_code;
  logic       key_valid;

  int n_checks = 0;
  int n_fail   = 0;
  int n_valid  = 0;
  int idle_bad = 0;
  bit running  = 1'b0;
  bit done     = 1'b0;
  logic [7:0] exp_q [$];

  always #5 clk = ~clk;

  key_release_debouncer #(
    .KEY_W(8), .CLK_HZ(1_000_000), .BLACKOUT_US(N), .SYNC_STAGES(2)
  ) uut (
    .clk(clk), .rst_n(rst_n), .raw_keys(raw_keys), .smp_en(smp_en),
    .key_code(key_code), .key_valid(key_valid)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: pops the scoreboard on every report.
  always @(negedge clk) begin
    if (running) begin
      if (key_valid) begin
        n_valid++;
        if (exp_q.size() == 0) chk(1'b0, "R5 unexpected report", key_code, 8'hFF);
        else begin
          automatic logic [7:0] e = exp_q.pop_front();
          chk(key_code == e, "R5 reported code", key_code, e);
        end
      end else if (key_code != 8'hFF) idle_bad++;
    end
  end

  task automatic expect_report(input logic [7:0] p);
    exp_q.push_back(p);
  endtask

  task automatic press(input logic [7:0] p);
    @(negedge clk);
    raw_keys = p;
    smp_en = 1'b1;
    repeat (SETTLE) @(negedge clk);
  endtask

  initial begin
    #(200_000 * 10);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    int base;
    int cnt;
    repeat (3) @(negedge clk);
    chk(key_code == 8'hFF, "R1 reset code", key_code, 8'hFF);
    chk(key_valid == 1'b0, "R1 reset valid", key_valid, 0);
    rst_n = 1'b1;
    running = 1'b1;
    repeat (3) @(negedge clk);
    chk(key_code == 8'hFF && !key_valid, "R1 idle after reset", key_code, 8'hFF);

    // R4 / R5: basic press then release
    base = n_valid;
    press(8'hFE);
    chk(n_valid == base, "R4 press silent", n_valid - base, 0);
    expect_report(8'hFE);
    press(8'hFF);
    chk(n_valid == base + 1, "R5 one report on release", n_valid - base, 1);
    base = n_valid;
    repeat (3 * SETTLE) @(negedge clk);
    chk(n_valid == base, "R5 idle after report", n_valid - base, 0);

    // R6: held pattern under repeated strobes
    press(8'hE7);
    base = n_valid;
    repeat (3 * SETTLE) @(negedge clk);
    chk(n_valid == base, "R6 held key silent", n_valid - base, 0);
    expect_report(8'hE7);
    press(8'hFF);

    // R4: move between pressed patterns, last one wins
    press(8'hF0);
    press(8'h0F);
    expect_report(8'h0F);
    base = n_valid;
    press(8'hFF);
    chk(n_valid == base + 1, "R4 rollover report", n_valid - base, 1);

    // R7: bounce inside blackout is ignored
    @(negedge clk);
    raw_keys = 8'h7E; smp_en = 1'b1;
    repeat (6) @(negedge clk);
    raw_keys = 8'hBD;
    repeat (5) @(negedge clk);
    raw_keys = 8'h7E;
    base = n_valid;
    repeat (SETTLE) @(negedge clk);
    chk(n_valid == base, "R7 bounce silent", n_valid - base, 0);
    expect_report(8'h7E);
    press(8'hFF);

    // R7: exact blackout length
    @(negedge clk);
    raw_keys = 8'hDB; smp_en = 1'b1;
    expect_report(8'hDB);
    cnt = 0;
    do begin
      @(negedge clk);
      cnt++;
      if (cnt == 3) raw_keys = 8'hFF;
    end while (!key_valid && cnt < 200);
    chk(cnt == N + 4, "R7 report edge", cnt, N + 4);
    repeat (SETTLE) @(negedge clk);

    // R3: no strobe, no decision
    @(negedge clk);
    smp_en = 1'b0; raw_keys = 8'hAA;
    repeat (SETTLE) @(negedge clk);
    raw_keys = 8'hFF;
    repeat (SETTLE) @(negedge clk);
    base = n_valid;
    smp_en = 1'b1;
    repeat (SETTLE) @(negedge clk);
    chk(n_valid == base, "R3 unstrobed press lost", n_valid - base, 0);
    smp_en = 1'b0; raw_keys = 8'h55;
    repeat (5) @(negedge clk);
    smp_en = 1'b1;
    repeat (SETTLE) @(negedge clk);
    expect_report(8'h55);
    base = n_valid;
    press(8'hFF);
    chk(n_valid == base + 1, "R3 strobed press kept", n_valid - base, 1);

    // R8: a strobe on the first two edges sees the old value
    @(negedge clk);
    smp_en = 1'b0;
    repeat (5) @(negedge clk);
    raw_keys = 8'hC3; smp_en = 1'b1;
    @(negedge clk);
    @(negedge clk);
    smp_en = 1'b0;
    raw_keys = 8'hFF;
    repeat (5) @(negedge clk);
    base = n_valid;
    smp_en = 1'b1;
    repeat (SETTLE) @(negedge clk);
    chk(n_valid == base, "R8 sync delay", n_valid - base, 0);

    chk(exp_q.size() == 0, "R5 all reports seen", exp_q.size(), 0);
    chk(idle_bad == 0, "R2 idle code", idle_bad, 0);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule